// File: doc/BRIEF.md
# Frame Memory Rectangle Copy Engine

This block moves a rectangle of 16-bit pixels from one place to another inside a frame memory that is 2^X_BITS pixels wide and 2^Y_BITS rows tall (1024 x 512 by default). A request arrives as three 32-bit words, one for the source corner, one for the destination corner and one for the extent, plus a bit that forces bit 15 of every written pixel to one. The engine drives a single-port memory with a one-cycle read latency and pulses `done` when the copy is complete.

Each row is split into chunks of at most CHUNK pixels. The whole chunk is read into a small local line buffer before any of it is written back. This fixes the result for overlapping rectangles and for rectangles that run off the right or bottom edge, where coordinates wrap around. Rows are visited from the lowest y upward. A request whose source and destination corners are equal, with the force bit clear, changes nothing, so it ends without touching memory.

Top module: `vcopy_engine`

## Requirements
- R1: The x coordinate of a corner is bits X_BITS-1:0 of its word, and the y coordinate is bits 16+Y_BITS-1:16 (9:0 and 24:16 by default). All other bits of the corner and size words are ignored.
- R2: A size field f gives an extent of ((f - 1) mod 2^N) + 1. Width uses bits X_BITS-1:0 with N = X_BITS, and height uses bits 16+Y_BITS-1:16 with N = Y_BITS. A field of zero therefore means the full frame width or height.
- R3: Every source and destination x is taken modulo 2^X_BITS and every y modulo 2^Y_BITS, so a rectangle crossing an edge continues on the opposite side.
- R4: Each written pixel equals the source pixel ORed with the force bit placed at bit 15.
- R5: When the source and destination corners are equal and the force bit is clear, `done` is high in the cycle after `start` and no memory request is made.
- R6: Each row is processed left to right in chunks of CHUNK pixels, the last chunk holding the remainder. All reads of a chunk happen before any of its writes, and the memory contents afterwards equal that ordering.
- R7: Rows are processed in increasing row order (offset 0 to height-1 from each corner), so a vertically overlapping copy follows that order.
- R8: `done` is a single-cycle pulse, one cycle after the final write of a copy.
- R9: `start` is accepted only while `busy` is low. A `start` while busy has no effect on the copy in progress or on the memory contents.
- R10: After reset, `busy`, `done` and `mem_req` are low.
- R11: The memory address is y * 2^X_BITS + x. Read data is taken from `mem_rdata` one cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a copy with the words presented this cycle |
| src_word | input | 32 | Source corner word |
| dst_word | input | 32 | Destination corner word |
| size_word | input | 32 | Width and height word |
| mask_en | input | 1 | Force bit 15 of written pixels to one |
| busy | output | 1 | A copy is in progress (includes the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | X_BITS+Y_BITS | Pixel address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read request |

## Verification
The bench builds the engine with X_BITS=4, Y_BITS=3 and CHUNK=4, giving a 16 x 8 frame of 128 pixels. With this size a zero size field (a full-frame copy), wrap on both axes, several chunks per row and a short final chunk can all be reached in a few hundred cycles. A sweep over every width from 1 to 16 at two heights, plus directed overlap, wrap, force-bit, identity and busy-start cases, is compared pixel by pixel against an arithmetic model of the chunked, row-ordered copy.

// File: rtl/vcopy_pkg.sv
package vcopy_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WAIT,
      ST_WRITE,
      ST_DONE
   } vc_state_e;
endpackage

// File: rtl/vcopy_decode.sv
module vcopy_decode #(
   parameter int X_BITS = 10,
   parameter int Y_BITS = 9
) (
   input  logic [31:0]       src_word,
   input  logic [31:0]       dst_word,
   input  logic [31:0]       size_word,
   input  logic              mask_en,
   output logic [X_BITS-1:0] sx,
   output logic [Y_BITS-1:0] sy,
   output logic [X_BITS-1:0] dx,
   output logic [Y_BITS-1:0] dy,
   output logic [X_BITS-1:0] wm1,
   output logic [Y_BITS-1:0] hm1,
   output logic              is_identity
);
   localparam int YLO = 16;

   assign sx  = src_word[X_BITS-1:0];
   assign sy  = src_word[YLO +: Y_BITS];
   assign dx  = dst_word[X_BITS-1:0];
   assign dy  = dst_word[YLO +: Y_BITS];
   // R2: extent minus one, wrapping a zero field to the full range
   assign wm1 = size_word[X_BITS-1:0] - X_BITS'(1);
   assign hm1 = size_word[YLO +: Y_BITS] - Y_BITS'(1);

   // R5: same corner and no forced bit means nothing would change
   assign is_identity = (sx == dx) && (sy == dy) && !mask_en;

   // R1: bits outside the coordinate fields take no part
   logic unused_bits;
   assign unused_bits = ^{src_word[31:YLO+Y_BITS], src_word[YLO-1:X_BITS],
                          dst_word[31:YLO+Y_BITS], dst_word[YLO-1:X_BITS],
                          size_word[31:YLO+Y_BITS], size_word[YLO-1:X_BITS]};
endmodule

// File: rtl/vcopy_linebuf.sv
module vcopy_linebuf #(
   parameter int DEPTH = 16,
   parameter int PIX_W = 16,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IW-1:0]    wr_idx,
   input  logic [PIX_W-1:0] wr_data,
   input  logic [IW-1:0]    rd_idx,
   output logic [PIX_W-1:0] rd_data
);
   logic [DEPTH*PIX_W-1:0] flat;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [PIX_W-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == IW'(g))) begin
            q <= wr_data;
         end
      end
      assign flat[g*PIX_W +: PIX_W] = q;
   end

   assign rd_data = flat[int'(rd_idx)*PIX_W +: PIX_W];
endmodule

// File: rtl/vcopy_seq.sv
module vcopy_seq
   import vcopy_pkg::*;
#(
   parameter int X_BITS = 10,
   parameter int Y_BITS = 9,
   parameter int CHUNK  = 16,
   localparam int IW    = $clog2(CHUNK),
   localparam int KW    = $clog2(CHUNK + 1),
   localparam int CW    = X_BITS + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [X_BITS-1:0] in_sx,
   input  logic [Y_BITS-1:0] in_sy,
   input  logic [X_BITS-1:0] in_dx,
   input  logic [Y_BITS-1:0] in_dy,
   input  logic [X_BITS-1:0] in_wm1,
   input  logic [Y_BITS-1:0] in_hm1,
   input  logic              in_mask,
   input  logic              in_identity,
   output vc_state_e         state,
   output logic [X_BITS-1:0] sx_q,
   output logic [Y_BITS-1:0] sy_q,
   output logic [X_BITS-1:0] dx_q,
   output logic [Y_BITS-1:0] dy_q,
   output logic              mask_q,
   output logic [Y_BITS-1:0] row_q,
   output logic [X_BITS-1:0] col_lo,
   output logic [IW-1:0]     k_q,
   output logic              cap_en,
   output logic [IW-1:0]     cap_idx,
   output logic              busy,
   output logic              done
);
   vc_state_e         st_q;
   logic [X_BITS-1:0] wm1_q;
   logic [Y_BITS-1:0] hm1_q;
   logic [CW-1:0]     col_q;
   logic [CW-1:0]     rem;
   logic [KW-1:0]     clen;
   logic              last_k;
   logic              last_chunk;
   logic              last_row;

   // pixels left in the current row, and the length of this chunk
   assign rem        = {1'b0, wm1_q} - col_q + CW'(1);
   assign last_chunk = (rem <= CW'(CHUNK));
   assign clen       = last_chunk ? KW'(rem) : KW'(CHUNK);
   assign last_k     = (KW'(k_q) == (clen - KW'(1)));
   assign last_row   = (row_q == hm1_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         sx_q    <= '0;
         sy_q    <= '0;
         dx_q    <= '0;
         dy_q    <= '0;
         wm1_q   <= '0;
         hm1_q   <= '0;
         mask_q  <= 1'b0;
         row_q   <= '0;
         col_q   <= '0;
         k_q     <= '0;
         cap_en  <= 1'b0;
         cap_idx <= '0;
      end else begin
         // R11: read data returns one cycle after the request
         cap_en  <= (st_q == ST_READ);
         cap_idx <= k_q;
         unique case (st_q)
            ST_IDLE: begin
               // R9: requests are taken only from the idle state
               if (start) begin
                  sx_q   <= in_sx;
                  sy_q   <= in_sy;
                  dx_q   <= in_dx;
                  dy_q   <= in_dy;
                  wm1_q  <= in_wm1;
                  hm1_q  <= in_hm1;
                  mask_q <= in_mask;
                  row_q  <= '0;
                  col_q  <= '0;
                  k_q    <= '0;
                  st_q   <= in_identity ? ST_DONE : ST_READ;
               end
            end
            ST_READ: begin
               if (last_k) begin
                  k_q  <= '0;
                  st_q <= ST_WAIT;
               end else begin
                  k_q <= k_q + IW'(1);
               end
            end
            ST_WAIT: begin
               st_q <= ST_WRITE;
            end
            ST_WRITE: begin
               if (last_k) begin
                  k_q <= '0;
                  if (last_chunk) begin
                     col_q <= '0;
                     if (last_row) begin
                        st_q <= ST_DONE;
                     end else begin
                        // R7: rows advance upward from the corner
                        row_q <= row_q + Y_BITS'(1);
                        st_q  <= ST_READ;
                     end
                  end else begin
                     col_q <= col_q + CW'(clen);
                     st_q  <= ST_READ;
                  end
               end else begin
                  k_q <= k_q + IW'(1);
               end
            end
            ST_DONE: begin
               st_q <= ST_IDLE;
            end
            default: begin
               st_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign state  = st_q;
   assign col_lo = col_q[X_BITS-1:0];
   assign busy   = (st_q != ST_IDLE);
   assign done   = (st_q == ST_DONE);
endmodule

// File: rtl/vcopy_agen.sv
module vcopy_agen
   import vcopy_pkg::*;
#(
   parameter int X_BITS = 10,
   parameter int Y_BITS = 9,
   parameter int CHUNK  = 16,
   parameter int PIX_W  = 16,
   localparam int IW    = $clog2(CHUNK),
   localparam int AW    = X_BITS + Y_BITS
) (
   input  vc_state_e         state,
   input  logic [X_BITS-1:0] sx,
   input  logic [Y_BITS-1:0] sy,
   input  logic [X_BITS-1:0] dx,
   input  logic [Y_BITS-1:0] dy,
   input  logic [Y_BITS-1:0] row,
   input  logic [X_BITS-1:0] col,
   input  logic [IW-1:0]     k,
   input  logic              mask,
   input  logic [PIX_W-1:0]  buf_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [PIX_W-1:0]  mem_wdata
);
   logic [X_BITS-1:0] xoff;
   logic [X_BITS-1:0] rx;
   logic [X_BITS-1:0] wx;
   logic [Y_BITS-1:0] ry;
   logic [Y_BITS-1:0] wy;

   // R3: sums are kept at field width so they wrap at the frame edge
   assign xoff = col + X_BITS'(k);
   assign rx   = sx + xoff;
   assign wx   = dx + xoff;
   assign ry   = sy + row;
   assign wy   = dy + row;

   always_comb begin
      mem_req = (state == ST_READ) || (state == ST_WRITE);
      mem_we  = (state == ST_WRITE);
      // R11: row-major address, row above column
      mem_addr = mem_we ? {wy, wx} : {ry, rx};
      // R4: forced bit lands on the top bit of the pixel
      mem_wdata = buf_data | (PIX_W'(mask) << (PIX_W - 1));
   end
endmodule

// File: rtl/vcopy_engine.sv
module vcopy_engine
   import vcopy_pkg::*;
#(
   parameter int X_BITS = 10,
   parameter int Y_BITS = 9,
   parameter int CHUNK  = 16,
   parameter int PIX_W  = 16,
   localparam int AW    = X_BITS + Y_BITS,
   localparam int IW    = $clog2(CHUNK)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [31:0]      src_word,
   input  logic [31:0]      dst_word,
   input  logic [31:0]      size_word,
   input  logic             mask_en,
   output logic             busy,
   output logic             done,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [PIX_W-1:0] mem_wdata,
   input  logic [PIX_W-1:0] mem_rdata
);
   if (X_BITS < 1 || X_BITS > 15) begin : g_bad_x
      $error("vcopy_engine: X_BITS must lie in 1..15");
   end
   if (Y_BITS < 1 || Y_BITS > 15) begin : g_bad_y
      $error("vcopy_engine: Y_BITS must lie in 1..15");
   end
   if (CHUNK < 2 || CHUNK > (1 << X_BITS)) begin : g_bad_chunk
      $error("vcopy_engine: CHUNK must lie in 2..2**X_BITS");
   end
   if (PIX_W < 2) begin : g_bad_pix
      $error("vcopy_engine: PIX_W must be at least 2");
   end

   logic [X_BITS-1:0] d_sx, d_dx, d_wm1, q_sx, q_dx, q_col;
   logic [Y_BITS-1:0] d_sy, d_dy, d_hm1, q_sy, q_dy, q_row;
   logic              d_ident, q_mask, cap_en;
   logic [IW-1:0]     k_idx, cap_idx;
   logic [PIX_W-1:0]  buf_rd;
   vc_state_e         st;

   vcopy_decode #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) dec_i (
      .src_word    (src_word),
      .dst_word    (dst_word),
      .size_word   (size_word),
      .mask_en     (mask_en),
      .sx          (d_sx),
      .sy          (d_sy),
      .dx          (d_dx),
      .dy          (d_dy),
      .wm1         (d_wm1),
      .hm1         (d_hm1),
      .is_identity (d_ident)
   );

   vcopy_seq #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .CHUNK(CHUNK)) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .in_sx       (d_sx),
      .in_sy       (d_sy),
      .in_dx       (d_dx),
      .in_dy       (d_dy),
      .in_wm1      (d_wm1),
      .in_hm1      (d_hm1),
      .in_mask     (mask_en),
      .in_identity (d_ident),
      .state       (st),
      .sx_q        (q_sx),
      .sy_q        (q_sy),
      .dx_q        (q_dx),
      .dy_q        (q_dy),
      .mask_q      (q_mask),
      .row_q       (q_row),
      .col_lo      (q_col),
      .k_q         (k_idx),
      .cap_en      (cap_en),
      .cap_idx     (cap_idx),
      .busy        (busy),
      .done        (done)
   );

   // R6: a chunk is held here between its reads and its writes
   vcopy_linebuf #(.DEPTH(CHUNK), .PIX_W(PIX_W)) lb_i (
      .clk     (clk),
      .wr_en   (cap_en),
      .wr_idx  (cap_idx),
      .wr_data (mem_rdata),
      .rd_idx  (k_idx),
      .rd_data (buf_rd)
   );

   vcopy_agen #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .CHUNK(CHUNK), .PIX_W(PIX_W)) agen_i (
      .state     (st),
      .sx        (q_sx),
      .sy        (q_sy),
      .dx        (q_dx),
      .dy        (q_dy),
      .row       (q_row),
      .col       (q_col),
      .k         (k_idx),
      .mask      (q_mask),
      .buf_data  (buf_rd),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );
endmodule

// File: rtl/vcopy_engine_chk.sv
module vcopy_engine_chk #(
   parameter int X_BITS = 10,
   parameter int Y_BITS = 9,
   parameter int PIX_W  = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [X_BITS-1:0] src_x,
   input logic [Y_BITS-1:0] src_y,
   input logic [X_BITS-1:0] dst_x,
   input logic [Y_BITS-1:0] dst_y,
   input logic             mask_en,
   input logic             busy,
   input logic             done,
   input logic             mem_req,
   input logic             mem_we,
   input logic [PIX_W-1:0] mem_wdata
);
   logic mask_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_seen <= 1'b0;
      end else if (start && !busy) begin
         mask_seen <= mask_en;
      end
   end

   // R5
   identity_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && src_x == dst_x && src_y == dst_y && !mask_en) |=> (done && !mem_req));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(mem_we) || $past(start && !busy)));

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   // R4
   mask_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mask_seen) |-> mem_wdata[PIX_W-1]);

   // R11
   req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);
endmodule

bind vcopy_engine vcopy_engine_chk #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .PIX_W(PIX_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .src_x     (src_word[X_BITS-1:0]),
   .src_y     (src_word[16 +: Y_BITS]),
   .dst_x     (dst_word[X_BITS-1:0]),
   .dst_y     (dst_word[16 +: Y_BITS]),
   .mask_en   (mask_en),
   .busy      (busy),
   .done      (done),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_wdata (mem_wdata)
);

// File: tb/vcopy_engine_tb_top.sv
module vcopy_engine_tb_top;
   localparam int XB   = 4;
   localparam int YB   = 3;
   localparam int CH   = 4;
   localparam int XW   = 1 << XB;
   localparam int YH   = 1 << YB;
   localparam int NPIX = XW * YH;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        start = 1'b0;
   logic [31:0] src_w = '0, dst_w = '0, size_w = '0;
   logic        mask_en = 1'b0;
   logic        busy, done, mem_req, mem_we;
   logic [XB+YB-1:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;

   vcopy_engine #(.X_BITS(XB), .Y_BITS(YB), .CHUNK(CH), .PIX_W(16)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .src_word(src_w), .dst_word(dst_w),
      .size_word(size_w), .mask_en(mask_en), .busy(busy), .done(done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   logic [15:0] vmem [NPIX];
   logic [15:0] refm [NPIX];
   logic        fill_req = 1'b0;
   int          fill_seed = 0;

   function automatic logic [15:0] pat(int i, int s);
      return 16'((i * 173 + s * 29 + 5) & 32'h7fff);
   endfunction

   // frame memory model: one port, read data one cycle after the request
   always @(posedge clk) begin
      if (fill_req) begin
         for (int i = 0; i < NPIX; i++) vmem[i] <= pat(i, fill_seed);
      end else if (mem_req) begin
         if (mem_we) vmem[mem_addr] <= mem_wdata;
         else        mem_rdata <= vmem[mem_addr];
      end
   end

   int cyc = 0, req_cnt = 0, last_we = -1, done_cyc = -1, done_cnt = 0;
   always @(negedge clk) begin
      cyc++;
      if (mem_req) req_cnt++;
      if (mem_we) last_we = cyc;
      if (done) begin
         done_cyc = cyc;
         done_cnt++;
      end
   end

   int n_chk = 0, n_fail = 0;

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // corner / size word with junk in every bit outside the fields (R1)
   function automatic logic [31:0] mkw(int lo, int hi);
      return {13'h1abc, 3'(hi), 12'hdef, 4'(lo)};
   endfunction

   // model: chunked read-then-write, rows upward, wrapped coordinates
   task automatic model_copy(input logic [31:0] s, input logic [31:0] d, input logic [31:0] z, input bit m);
      int sx, sy, dx, dy, w, h, n;
      logic [15:0] lb [CH];
      sx = int'(s[XB-1:0]);
      sy = int'(s[16 +: YB]);
      dx = int'(d[XB-1:0]);
      dy = int'(d[16 +: YB]);
      w  = ((int'(z[XB-1:0]) - 1) & (XW - 1)) + 1;
      h  = ((int'(z[16 +: YB]) - 1) & (YH - 1)) + 1;
      if (sx == dx && sy == dy && !m) return;
      for (int r = 0; r < h; r++) begin
         for (int c = 0; c < w; c += CH) begin
            n = (w - c < CH) ? (w - c) : CH;
            for (int k = 0; k < n; k++)
               lb[k] = refm[((sy + r) % YH) * XW + ((sx + c + k) % XW)];
            for (int k = 0; k < n; k++)
               refm[((dy + r) % YH) * XW + ((dx + c + k) % XW)] = lb[k] | (m ? 16'h8000 : 16'h0000);
         end
      end
   endtask

   int seed = 1;

   task automatic run_op(input logic [31:0] s, input logic [31:0] d, input logic [31:0] z,
                         input bit m, input string req, input bit ident, input bit poke);
      int t, base_req, base_done, mism, bad_a, bad_v, bad_e;
      @(negedge clk);
      fill_seed = seed;
      fill_req  = 1'b1;
      @(negedge clk);
      fill_req = 1'b0;
      for (int i = 0; i < NPIX; i++) refm[i] = pat(i, seed);
      seed++;
      model_copy(s, d, z, m);
      base_req  = req_cnt;
      base_done = done_cnt;
      src_w = s; dst_w = d; size_w = z; mask_en = m;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t = 0;
      if (poke) begin
         // R9: identity request while busy must be ignored
         @(negedge clk); @(negedge clk);
         src_w = mkw(3, 2); dst_w = mkw(3, 2); size_w = mkw(1, 1); mask_en = 1'b0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         t = 3;
      end
      while (!done && t < 5000) begin
         @(negedge clk);
         t++;
      end
      check(t < 5000, req, "copy finished (timeout)", t, 0);
      if (ident) check(t == 0, "R5", "cycles from start to done", t, 0);
      @(negedge clk);
      check(done_cnt - base_done == 1, "R8", "done pulses per copy", done_cnt - base_done, 1);
      check(!busy && !done, "R8", "idle after done", int'(busy) + int'(done), 0);
      if (ident)
         check(req_cnt == base_req, "R5", "memory requests on identity copy", req_cnt - base_req, 0);
      else
         check(done_cyc - last_we == 1, "R8", "cycles from last write to done", done_cyc - last_we, 1);
      mism = 0; bad_a = 0; bad_v = 0; bad_e = 0;
      for (int i = 0; i < NPIX; i++) begin
         if (vmem[i] !== refm[i]) begin
            if (mism == 0) begin
               bad_a = i; bad_v = int'(vmem[i]); bad_e = int'(refm[i]);
            end
            mism++;
         end
      end
      check(mism == 0, req, $sformatf("frame image, first bad pixel %0d (%0d mismatches)", bad_a, mism), bad_v, bad_e);
   endtask

   initial begin
      #2000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check(!busy, "R10", "busy in reset", int'(busy), 0);
      check(!done, "R10", "done in reset", int'(done), 0);
      check(!mem_req, "R10", "mem_req in reset", int'(mem_req), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !mem_req, "R10", "idle after reset release", int'(busy), 0);

      // R1 R11: plain copy, junk bits around every field
      run_op(mkw(1, 0), mkw(8, 4), mkw(3, 2), 1'b0, "R1", 1'b0, 1'b0);
      // R6: rightward overlap over three chunks (4,4,2)
      run_op(mkw(0, 2), mkw(1, 2), mkw(10, 1), 1'b0, "R6", 1'b0, 1'b0);
      // R3: x wraps on both sides
      run_op(mkw(14, 1), mkw(13, 5), mkw(5, 2), 1'b0, "R3", 1'b0, 1'b0);
      // R3: y wraps on both sides
      run_op(mkw(3, 6), mkw(9, 7), mkw(2, 4), 1'b0, "R3", 1'b0, 1'b0);
      // R7: downward overlap follows increasing row order
      run_op(mkw(4, 2), mkw(4, 3), mkw(3, 4), 1'b0, "R7", 1'b0, 1'b0);
      // R2: zero size fields mean 16 x 8
      run_op(mkw(5, 3), mkw(0, 0), mkw(0, 0), 1'b0, "R2", 1'b0, 1'b0);
      // R4: forced bit on an identity-position copy still writes
      run_op(mkw(2, 2), mkw(2, 2), mkw(6, 2), 1'b1, "R4", 1'b0, 1'b0);
      // R5: identity copy is skipped
      run_op(mkw(7, 5), mkw(7, 5), mkw(9, 3), 1'b0, "R5", 1'b1, 1'b0);
      // R9: start while busy ignored
      run_op(mkw(6, 0), mkw(1, 4), mkw(7, 3), 1'b0, "R9", 1'b0, 1'b1);

      // R6 R2 R4: sweep of every width at two heights
      for (int w = 1; w <= XW; w++) begin
         for (int hs = 0; hs < 2; hs++) begin
            int h;
            h = hs ? 3 : 1;
            run_op(mkw((w * 7) % XW, w % YH), mkw((w * 3 + h) % XW, (w + h * 2) % YH),
                   mkw(w % XW, h), (w % 3) == 0, "R6", 1'b0, 1'b0);
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule